// File: doc/BRIEF.md
# Packed Two-Lane Extreme Search

This block scans a stream of 32-bit words and reports the single largest or smallest signed 16-bit value in the stream, together with that value's element position. Each word carries two signed half-words. Both halves are examined in the same cycle, and each half goes to its own lane.

Each lane keeps a running extreme and the position at which that extreme was found. A lane takes a new value when the candidate beats the held value or equals it. When the word flagged as the end of a scan is accepted, the two lanes are merged into one answer. That answer is registered and flagged by a one-cycle completion pulse. A new scan can start on the very next cycle.

Top module: `pkmm_search`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `res_done` = 0, `res_value` = 0 and `res_index` = 0. A scan cut short by reset leaves no trace in the next scan.
- R2: Bits [15:0] of word w are element 2w and bits [31:16] are element 2w+1. Both are read as two's-complement signed values, so 0x8000 is the smallest value and 0x7FFF is the largest.
- R3: With `seek_min` = 0, the result is the greatest element of the scan.
- R4: With `seek_min` = 1, the result is the least element of the scan.
- R5: Within one lane an equal value replaces the held one. A lane therefore reports the highest position holding its extreme.
- R6: When the two lanes finish with equal values, the result index is the larger of the two lane positions. Together with R5, the reported index is the last occurrence of the extreme in the whole scan.
- R7: The first word of every scan loads both lanes directly. No value from an earlier scan affects the result, even when scans follow each other with no idle cycle.
- R8: `res_done` is high for exactly the one cycle after the cycle in which a word with `in_last` = 1 is accepted. `res_value` and `res_index` hold their values until the next completion.
- R9: `seek_min` is sampled with the first word of a scan. Later changes within the same scan have no effect.
- R10: While `in_valid` is 0, `in_word` and `in_last` are ignored and element positions do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seek_min | input | 1 | 0 searches for the maximum, 1 for the minimum |
| in_valid | input | 1 | `in_word` carries a word this cycle |
| in_last | input | 1 | This word ends the scan |
| in_word | input | 32 | Two packed signed half-words, low half first |
| res_done | output | 1 | One-cycle pulse: the result is new |
| res_value | output | 16 | Signed extreme value of the finished scan |
| res_index | output | 16 | Element position of that value |

## Verification
Several properties are checked on every cycle by assertions:
- each lane's held value only moves in the chosen direction during a scan;
- a lane's position pointer follows each replacement and each tie;
- the merged result is always one of the two lane candidates;
- a lane tie picks the larger position;
- outputs stay frozen between completions, and reset clears them.

Other behaviour can only be shown by the bench's scenarios, each checked against an element-by-element reference:
- the overall extreme and its last position;
- signed handling of the values at the edges of the range;
- sampling of the mode only at scan start;
- idle cycles carrying junk data;
- back-to-back scans;
- a reset that interrupts a scan.

// File: rtl/pkmm_pkg.sv
// Shared types for the packed extreme search.
package pkmm_pkg;
    // Direction of the search; the value equals the seek_min pin.
    typedef enum logic {
        PK_SEEK_MAX = 1'b0,
        PK_SEEK_MIN = 1'b1
    } pk_seek_e;
endpackage

// File: rtl/pkmm_cmp.sv
// Signed comparator for one lane.
// Asserts take_o when cand_i should replace held_i: greater-or-equal when
// searching for the maximum, less-or-equal when searching for the minimum.
// Assumes both operands are two's complement of width W.
module pkmm_cmp
    import pkmm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [W-1:0] cand_i,
    input  logic signed [W-1:0] held_i,
    input  pk_seek_e            seek_i,
    output logic                take_o
);
    // Inclusive comparison in the selected direction.
    always_comb begin
        if (seek_i == PK_SEEK_MAX) take_o = (cand_i >= held_i);
        else                       take_o = (cand_i <= held_i);
    end
endmodule

// File: rtl/pkmm_lane.sv
// One search lane: holds the running extreme and its element position.
// On a step it loads the candidate when load_i is set (the first word of a
// scan) or when the comparator says the candidate wins, ties included.
// The next-state values are exported so the merge can use them in the same
// cycle. Assumes seek_i is stable for the whole scan (the top guarantees it).
module pkmm_lane
    import pkmm_pkg::*;
#(
    parameter int W  = 16,
    parameter int IW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    input  logic                load_i,
    input  pk_seek_e            seek_i,
    input  logic signed [W-1:0] cand_i,
    input  logic [IW-1:0]       cand_idx_i,
    output logic signed [W-1:0] val_nx_o,
    output logic [IW-1:0]       idx_nx_o
);
    logic signed [W-1:0] val_q;
    logic [IW-1:0]       idx_q;
    logic                take;

    pkmm_cmp #(.W(W)) u_cmp (
        .cand_i (cand_i),
        .held_i (val_q),
        .seek_i (seek_i),
        .take_o (take)
    );

    // Next-state choice: keep the held pair or replace it with the candidate.
    always_comb begin
        val_nx_o = val_q;
        idx_nx_o = idx_q;
        if (step_i && (load_i || take)) begin
            val_nx_o = cand_i;
            idx_nx_o = cand_idx_i;
        end
    end

    // Running-extreme register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            idx_q <= '0;
        end else begin
            val_q <= val_nx_o;
            idx_q <= idx_nx_o;
        end
    end

    // Within a scan the held value only moves in the search direction.
    assert_lane_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=>
            (($past(seek_i) == PK_SEEK_MAX) ? (val_q >= $past(val_q))
                                            : (val_q <= $past(val_q))));

    // A tie moves the pointer to the newer element.
    assert_lane_tie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && (cand_i == val_q)) |=> (idx_q == $past(cand_idx_i)));

    // A changed value always carries the candidate's position.
    assert_lane_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> ((val_q == $past(val_q)) || (idx_q == $past(cand_idx_i))));
endmodule

// File: rtl/pkmm_merge.sv
// Merges the two lane results into one.
// The same inclusive comparison as in the lanes decides which lane wins.
// On equal values the larger position wins, so the overall answer is the
// last occurrence of the extreme. Purely combinational.
module pkmm_merge
    import pkmm_pkg::*;
#(
    parameter int W  = 16,
    parameter int IW = 16
) (
    input  logic signed [W-1:0] lo_val_i,
    input  logic [IW-1:0]       lo_idx_i,
    input  logic signed [W-1:0] hi_val_i,
    input  logic [IW-1:0]       hi_idx_i,
    input  pk_seek_e            seek_i,
    output logic signed [W-1:0] val_o,
    output logic [IW-1:0]       idx_o
);
    logic lo_holds;

    pkmm_cmp #(.W(W)) u_cmp (
        .cand_i (lo_val_i),
        .held_i (hi_val_i),
        .seek_i (seek_i),
        .take_o (lo_holds)
    );

    // The high lane wins when strictly better, or when tied at a later position.
    always_comb begin
        if (!lo_holds || ((lo_val_i == hi_val_i) && (hi_idx_i > lo_idx_i))) begin
            val_o = hi_val_i;
            idx_o = hi_idx_i;
        end else begin
            val_o = lo_val_i;
            idx_o = lo_idx_i;
        end
    end
endmodule

// File: rtl/pkmm_search.sv
// Top of the packed two-lane extreme search.
// It accepts one word per cycle when in_valid is high. Each word holds two
// signed halves: the low half is element 2w and the high half is element 2w+1.
// The search mode is latched with the first word of each scan. The merged
// result is registered together with a one-cycle done pulse.
// Assumes a scan holds at most 2**(IDX_W-1) words.
module pkmm_search
    import pkmm_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int IDX_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     seek_min,
    input  logic                     in_valid,
    input  logic                     in_last,
    input  logic [2*LANE_W-1:0]      in_word,
    output logic                     res_done,
    output logic signed [LANE_W-1:0] res_value,
    output logic [IDX_W-1:0]         res_index
);
    localparam int LANES = 2;
    localparam int CNT_W = IDX_W - 1;

    logic                     in_scan_q;
    logic [CNT_W-1:0]         word_cnt_q;
    pk_seek_e                 seek_q;
    pk_seek_e                 seek_eff;
    logic                     first_word;
    logic                     end_accept;
    logic signed [LANE_W-1:0] lane_val_nx [LANES];
    logic [IDX_W-1:0]         lane_idx_nx [LANES];
    logic signed [LANE_W-1:0] merge_val;
    logic [IDX_W-1:0]         merge_idx;

    // Scan-start detection and the mode used for the current word.
    always_comb begin
        first_word = !in_scan_q;
        end_accept = in_valid && in_last;
        seek_eff   = first_word ? pk_seek_e'(seek_min) : seek_q;
    end

    // Scan state: whether a scan is open, the word counter and the latched mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_scan_q  <= 1'b0;
            word_cnt_q <= '0;
            seek_q     <= PK_SEEK_MAX;
        end else if (in_valid) begin
            if (first_word) seek_q <= seek_eff;
            if (in_last) begin
                in_scan_q  <= 1'b0;
                word_cnt_q <= '0;
            end else begin
                in_scan_q  <= 1'b1;
                word_cnt_q <= word_cnt_q + CNT_W'(1);
            end
        end
    end

    // One lane per packed half; the element position is {word count, lane}.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic LANE_BIT = (g == 1);
        pkmm_lane #(.W(LANE_W), .IW(IDX_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .step_i     (in_valid),
            .load_i     (first_word),
            .seek_i     (seek_eff),
            .cand_i     (in_word[g*LANE_W +: LANE_W]),
            .cand_idx_i ({word_cnt_q, LANE_BIT}),
            .val_nx_o   (lane_val_nx[g]),
            .idx_nx_o   (lane_idx_nx[g])
        );
    end

    pkmm_merge #(.W(LANE_W), .IW(IDX_W)) u_merge (
        .lo_val_i (lane_val_nx[0]),
        .lo_idx_i (lane_idx_nx[0]),
        .hi_val_i (lane_val_nx[1]),
        .hi_idx_i (lane_idx_nx[1]),
        .seek_i   (seek_eff),
        .val_o    (merge_val),
        .idx_o    (merge_idx)
    );

    // Result register: captures the merge when the closing word is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_done  <= 1'b0;
            res_value <= '0;
            res_index <= '0;
        end else begin
            res_done <= end_accept;
            if (end_accept) begin
                res_value <= merge_val;
                res_index <= merge_idx;
            end
        end
    end

    // Reset clears every output on the following cycle.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!res_done && (res_value == '0) && (res_index == '0)));

    // Without a closing word there is no pulse and the result stays frozen.
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !end_accept |=> (!res_done && $stable(res_value) && $stable(res_index)));

    // The published pair always comes from one of the two lanes.
    assert_merge_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        end_accept |=> res_done &&
            (((res_value == $past(lane_val_nx[0])) && (res_index == $past(lane_idx_nx[0]))) ||
             ((res_value == $past(lane_val_nx[1])) && (res_index == $past(lane_idx_nx[1])))));

    // Equal lane values resolve to the larger position.
    assert_merge_tie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (end_accept && (lane_val_nx[0] == lane_val_nx[1])) |=>
            (res_index == (($past(lane_idx_nx[1]) > $past(lane_idx_nx[0]))
                           ? $past(lane_idx_nx[1]) : $past(lane_idx_nx[0]))));
endmodule

// File: tb/tb_pkmm_search.sv
`timescale 1ns/1ps
module tb_pkmm_search;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               seek_min;
    logic               in_valid;
    logic               in_last;
    logic [31:0]        in_word;
    logic               res_done;
    logic signed [15:0] res_value;
    logic [15:0]        res_index;

    always #2 clk = ~clk;

    pkmm_search dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .seek_min  (seek_min),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_word   (in_word),
        .res_done  (res_done),
        .res_value (res_value),
        .res_index (res_index)
    );

    typedef struct {
        int    val;
        int    idx;
        string req;
    } exp_t;

    exp_t        expq[$];
    logic [31:0] words[$];
    int          checks   = 0;
    int          failures = 0;
    int          held_val = 0;
    int          held_idx = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int lo, input int hi);
        logic [15:0] l;
        logic [15:0] h;
        l = lo[15:0];
        h = hi[15:0];
        return {h, l};
    endfunction

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    // Driver: computes the expected result from the words, queues it, drives the scan.
    task automatic run_scan(input bit mode, input bit gaps, input bit flip, input string req);
        exp_t e;
        int   best = 0;
        int   bidx = 0;
        bit   have = 0;
        for (int w = 0; w < words.size(); w++) begin
            for (int h = 0; h < 2; h++) begin
                logic signed [15:0] hv;
                int v;
                hv = h ? words[w][31:16] : words[w][15:0];
                v  = hv;
                if (!have || (mode ? (v <= best) : (v >= best))) begin
                    best = v;
                    bidx = 2 * w + h;
                    have = 1;
                end
            end
        end
        e.val = best;
        e.idx = bidx;
        e.req = req;
        expq.push_back(e);
        held_val = best;
        held_idx = bidx;
        for (int w = 0; w < words.size(); w++) begin
            if (gaps && (w % 2 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_word  = $urandom;
                in_last  = 1'($urandom);
                seek_min = 1'($urandom);
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_word  = words[w];
            in_last  = (w == words.size() - 1);
            seek_min = (flip && w > 0) ? ~mode : mode;
        end
    endtask

    // Monitor: pops the scoreboard on every completion pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && res_done === 1'b1) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R8", "unexpected done pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(res_value == e.val, e.req, "value", res_value, e.val);
                    check(int'(res_index) == e.idx, e.req, "index", res_index, e.idx);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        seek_min = 1'b0;
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_word  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(res_done == 1'b0, "R1", "done after reset", res_done, 0);
        check(res_value == 0, "R1", "value after reset", res_value, 0);
        check(res_index == 0, "R1", "index after reset", res_index, 0);

        // R3: mixed signs, maximum
        words.delete();
        words.push_back(mk(3, -7));
        words.push_back(mk(120, 44));
        words.push_back(mk(-5, 119));
        run_scan(1'b0, 1'b0, 1'b0, "R3");
        idle(3);

        // R4: the same data, minimum
        run_scan(1'b1, 1'b0, 1'b0, "R4");
        idle(3);

        // R8: result held after completion, no extra pulse
        idle(4);
        check(res_done == 1'b0, "R8", "done stays low", res_done, 0);
        check(res_value == held_val, "R8", "value held", res_value, held_val);
        check(int'(res_index) == held_idx, "R8", "index held", res_index, held_idx);

        // R2: signed edges of the range
        words.delete();
        words.push_back(mk(16'sh7FFF, -32768));
        words.push_back(mk(0, -1));
        run_scan(1'b0, 1'b0, 1'b0, "R2");
        run_scan(1'b1, 1'b0, 1'b0, "R2");
        idle(2);

        // R5: tie inside the low lane, the later element wins
        words.delete();
        words.push_back(mk(5, 1));
        words.push_back(mk(5, 2));
        words.push_back(mk(3, 0));
        run_scan(1'b0, 1'b0, 1'b0, "R5");
        idle(2);

        // R6: single word with equal halves, index 1
        words.delete();
        words.push_back(mk(-9, -9));
        run_scan(1'b1, 1'b0, 1'b0, "R6");
        idle(2);

        // R6: cross-lane tie where the low lane holds the later position
        words.delete();
        words.push_back(mk(1, 9));
        words.push_back(mk(9, 0));
        run_scan(1'b0, 1'b0, 1'b0, "R6");
        idle(2);

        // R10: idle cycles carrying junk between words
        words.delete();
        words.push_back(mk(10, 20));
        words.push_back(mk(30, -4));
        words.push_back(mk(7, 25));
        words.push_back(mk(-40, 2));
        run_scan(1'b0, 1'b1, 1'b0, "R10");
        idle(2);

        // R9: mode input flipped after the first word has no effect
        run_scan(1'b1, 1'b0, 1'b1, "R9");
        idle(2);

        // R7: back-to-back scans; the second scan holds only smaller values
        words.delete();
        words.push_back(mk(1000, 999));
        run_scan(1'b0, 1'b0, 1'b0, "R7");
        words.delete();
        words.push_back(mk(-3, -8));
        words.push_back(mk(-2, -6));
        run_scan(1'b0, 1'b0, 1'b0, "R7");
        idle(3);

        // R1: reset in the middle of a scan, then a fresh scan
        @(negedge clk);
        in_valid = 1'b1;
        in_last  = 1'b0;
        in_word  = mk(30000, 30000);
        seek_min = 1'b0;
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        words.delete();
        words.push_back(mk(4, 6));
        words.push_back(mk(-1, 2));
        run_scan(1'b0, 1'b0, 1'b0, "R1");
        idle(3);

        // R3/R4: pseudo-random scans
        for (int s = 0; s < 24; s++) begin
            int n;
            bit m;
            n = 1 + int'($urandom_range(0, 11));
            m = 1'($urandom);
            words.delete();
            for (int k = 0; k < n; k++) begin
                words.push_back(mk(int'($urandom_range(0, 7)) - 4, int'($urandom)));
            end
            run_scan(m, 1'($urandom), 1'($urandom), m ? "R4" : "R3");
            if (s % 3 == 0) idle(1);
        end
        idle(4);
        check(expq.size() == 0, "R8", "results outstanding", expq.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule